// File: doc/BRIEF.md
# Card Socket DMA Handshake Remapper

This block lets a 16-bit PC Card style I/O socket run DMA transfers without extra pins. A two-bit source field names one of three existing card inputs as an active-low DMA request. The chosen request is synchronized and passed to the host DMA controller as an active-high request.

During a qualified DMA transfer, the register-select pin becomes an active-high acknowledge. The terminal count rides on whichever strobe pin the transfer direction leaves unused. Outside DMA transfers, every strobe passes straight through. When a pin is claimed for the request, its other uses are suppressed: the write-protect status, the speaker output, or the input-acknowledge enable.

Remapping applies only when the socket is in I/O card mode (`io_mode` = 1) and the source field is non-zero. In this document that condition is called "DMA enabled".

Top module: `card_dma_remap`

## Requirements
- R1: Source field `dma_src` selects the request pin: 2'b01 = `card_inpack_n`, 2'b10 = `card_wp_io16_n`, 2'b11 = `card_bvd2_spkr_n`. A low level on the selected pin raises `host_dreq`.
- R2: With `dma_src` = 2'b00 or `io_mode` = 0, `host_dreq` is 0 in the same cycle, and `card_reg_n`, `card_oe_n` and `card_we_n` equal `host_reg_n`, `host_oe_n` and `host_we_n`.
- R3: A change on the selected request pin reaches `host_dreq` after exactly two rising clock edges.
- R4: A DMA strobe is `host_dack` = 1 while DMA is enabled and either I/O strobe is low. During a DMA strobe, `card_reg_n` is 1. Otherwise it equals `host_reg_n`.
- R5: During a DMA write strobe (`host_iord_n` = 0), `card_oe_n` = NOT `host_tc` and `card_we_n` = `host_we_n`.
- R6: During a DMA read strobe (`host_iowr_n` = 0, `host_iord_n` = 1), `card_we_n` = NOT `host_tc` and `card_oe_n` = `host_oe_n`.
- R7: Without a DMA strobe, `card_oe_n` and `card_we_n` equal the host strobes whatever `host_tc` is.
- R8: With DMA enabled and source 2'b10, `stat_wp_lvl` shows the synchronized request (1 = requesting). Otherwise it shows the `card_wp_io16_n` level.
- R9: With DMA enabled and source 2'b11, `spkr_out` is 0. Otherwise it equals NOT `card_bvd2_spkr_n`.
- R10: With DMA enabled and source 2'b01, `inack_en` is 0. Otherwise it equals `cfg_inack_en`.
- R11: While `rst_n` is low, `host_dreq` is 0 even when a request pin is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| io_mode | input | 1 | Socket is in I/O card mode |
| dma_src | input | 2 | DMA request source field |
| cfg_inack_en | input | 1 | Configured input-acknowledge enable |
| card_inpack_n | input | 1 | Card input-acknowledge pin |
| card_wp_io16_n | input | 1 | Card write-protect / IO-16 pin |
| card_bvd2_spkr_n | input | 1 | Card battery-voltage-2 / speaker pin |
| host_dack | input | 1 | Host DMA acknowledge for current cycle |
| host_tc | input | 1 | Host terminal count, final transfer |
| host_iord_n | input | 1 | Host I/O read strobe |
| host_iowr_n | input | 1 | Host I/O write strobe |
| host_reg_n | input | 1 | Host register-select |
| host_oe_n | input | 1 | Host output enable |
| host_we_n | input | 1 | Host write enable |
| host_dreq | output | 1 | Synchronized DMA request to host |
| stat_wp_lvl | output | 1 | Status bit: write-protect or request level |
| card_reg_n | output | 1 | Card register-select / acknowledge |
| card_oe_n | output | 1 | Card output enable / terminal count |
| card_we_n | output | 1 | Card write enable / terminal count |
| spkr_out | output | 1 | Speaker output from socket |
| inack_en | output | 1 | Effective input-acknowledge enable |

## Verification
The hardest case to reach is the status bit under source 2'b10. There it must follow the synchronized request with its two-edge lag, not the raw pin. A pin-level check alone would miss that lag.

The stimulus sets source 2'b10 and drops the write-protect pin half a cycle before an edge. It then samples `host_dreq` and `stat_wp_lvl` after one edge and again after two. Next it moves to source 2'b01 with the same pin low, so the status bit must fall back to the raw pin level.

// File: rtl/card_dma_pkg.sv
package card_dma_pkg;
    typedef enum logic [1:0] {
        SRC_OFF   = 2'b00,
        SRC_INACK = 2'b01,
        SRC_WP    = 2'b10,
        SRC_SPKR  = 2'b11
    } dma_src_e;
endpackage

// File: rtl/card_dma_req_sync.sv
module card_dma_req_sync
    import card_dma_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       dma_on,
    input  logic [1:0] src,
    input  logic       inpack_n,
    input  logic       wp_n,
    input  logic       bvd2_n,
    output logic       req_sync,
    output logic       dreq
);
    localparam int LAST = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0] sh;
    } sync_t;

    sync_t s_d, s_q;
    logic  raw;

    always_comb begin
        unique case (dma_src_e'(src))
            SRC_INACK: raw = ~inpack_n;
            SRC_WP:    raw = ~wp_n;
            SRC_SPKR:  raw = ~bvd2_n;
            default:   raw = 1'b0;
        endcase
        raw     = raw & dma_on;
        s_d.sh  = {s_q.sh[STAGES-2:0], raw};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign req_sync = s_q.sh[LAST];
    assign dreq     = req_sync & dma_on;

    // R2
    dreq_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_on |-> !dreq);
    // R3
    sync_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_sync) |-> $past(raw, 2));
    // R11
    rst_quiet_chk: assert property (@(posedge clk)
        !rst_n |-> !dreq);
endmodule

// File: rtl/card_dma_strobe_mux.sv
module card_dma_strobe_mux (
    input  logic clk,
    input  logic rst_n,
    input  logic dma_on,
    input  logic dack,
    input  logic tc,
    input  logic iord_n,
    input  logic iowr_n,
    input  logic reg_n,
    input  logic oe_n,
    input  logic we_n,
    output logic card_reg_n,
    output logic card_oe_n,
    output logic card_we_n
);
    logic dma_strobe, dma_wr, dma_rd;

    always_comb begin
        dma_strobe = dma_on & dack & (~iord_n | ~iowr_n);
        dma_wr     = dma_strobe & ~iord_n;
        dma_rd     = dma_strobe & iord_n & ~iowr_n;
        card_reg_n = dma_strobe ? 1'b1 : reg_n;
        card_oe_n  = dma_wr ? ~tc : oe_n;
        card_we_n  = dma_rd ? ~tc : we_n;
    end

    // R4
    ack_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_on && dack && !iord_n) |-> card_reg_n);
    // R7
    tc_outside_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dack || (iord_n && iowr_n)) |-> (card_oe_n == oe_n && card_we_n == we_n));
    // R5
    wr_we_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!iord_n) |-> (card_we_n == we_n));
endmodule

// File: rtl/card_dma_pin_claim.sv
module card_dma_pin_claim
    import card_dma_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       dma_on,
    input  logic [1:0] src,
    input  logic       req_sync,
    input  logic       wp_n,
    input  logic       bvd2_n,
    input  logic       cfg_inack_en,
    output logic       stat_wp_lvl,
    output logic       spkr_out,
    output logic       inack_en
);
    logic take_wp, take_spkr, take_inack;

    always_comb begin
        take_inack  = dma_on & (dma_src_e'(src) == SRC_INACK);
        take_wp     = dma_on & (dma_src_e'(src) == SRC_WP);
        take_spkr   = dma_on & (dma_src_e'(src) == SRC_SPKR);
        stat_wp_lvl = take_wp ? req_sync : wp_n;
        spkr_out    = take_spkr ? 1'b0 : ~bvd2_n;
        inack_en    = take_inack ? 1'b0 : cfg_inack_en;
    end

    // R9
    spkr_mute_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_on && src == 2'b11) |-> !spkr_out);
    // R10
    inack_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_on && src == 2'b01) |-> !inack_en);
    // R8
    stat_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src != 2'b10) |-> (stat_wp_lvl == wp_n));
endmodule

// File: rtl/card_dma_remap.sv
module card_dma_remap
    import card_dma_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       io_mode,
    input  logic [1:0] dma_src,
    input  logic       cfg_inack_en,
    input  logic       card_inpack_n,
    input  logic       card_wp_io16_n,
    input  logic       card_bvd2_spkr_n,
    input  logic       host_dack,
    input  logic       host_tc,
    input  logic       host_iord_n,
    input  logic       host_iowr_n,
    input  logic       host_reg_n,
    input  logic       host_oe_n,
    input  logic       host_we_n,
    output logic       host_dreq,
    output logic       stat_wp_lvl,
    output logic       card_reg_n,
    output logic       card_oe_n,
    output logic       card_we_n,
    output logic       spkr_out,
    output logic       inack_en
);
    logic dma_on;
    logic req_sync;

    assign dma_on = io_mode & (dma_src != SRC_OFF);

    card_dma_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .dma_on   (dma_on),
        .src      (dma_src),
        .inpack_n (card_inpack_n),
        .wp_n     (card_wp_io16_n),
        .bvd2_n   (card_bvd2_spkr_n),
        .req_sync (req_sync),
        .dreq     (host_dreq)
    );

    card_dma_strobe_mux u_mux (
        .clk        (clk),
        .rst_n      (rst_n),
        .dma_on     (dma_on),
        .dack       (host_dack),
        .tc         (host_tc),
        .iord_n     (host_iord_n),
        .iowr_n     (host_iowr_n),
        .reg_n      (host_reg_n),
        .oe_n       (host_oe_n),
        .we_n       (host_we_n),
        .card_reg_n (card_reg_n),
        .card_oe_n  (card_oe_n),
        .card_we_n  (card_we_n)
    );

    card_dma_pin_claim u_claim (
        .clk          (clk),
        .rst_n        (rst_n),
        .dma_on       (dma_on),
        .src          (dma_src),
        .req_sync     (req_sync),
        .wp_n         (card_wp_io16_n),
        .bvd2_n       (card_bvd2_spkr_n),
        .cfg_inack_en (cfg_inack_en),
        .stat_wp_lvl  (stat_wp_lvl),
        .spkr_out     (spkr_out),
        .inack_en     (inack_en)
    );

    // R1
    src_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_dreq |-> dma_on);
endmodule

// File: tb/card_dma_remap_tb_top.sv
module card_dma_remap_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic io_mode = 1'b0, cfg_inack_en = 1'b0;
    logic [1:0] dma_src = 2'b00;
    logic card_inpack_n = 1'b1, card_wp_io16_n = 1'b1, card_bvd2_spkr_n = 1'b1;
    logic host_dack = 1'b0, host_tc = 1'b0, host_iord_n = 1'b1, host_iowr_n = 1'b1;
    logic host_reg_n = 1'b1, host_oe_n = 1'b1, host_we_n = 1'b1;
    logic host_dreq, stat_wp_lvl, card_reg_n, card_oe_n, card_we_n, spkr_out, inack_en;
    int errs = 0, checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    card_dma_remap dut_i (.*);

    // {io,src[1:0],dack,iord_n,iowr_n,tc,reg_n,oe_n,we_n, exp reg,oe,we}
    localparam logic [12:0] VEC [9] = '{
        13'b1_10_1_0_1_1_0_1_1_1_0_1,   // DMA write, tc -> OE low (R5)
        13'b1_10_1_0_1_0_0_1_1_1_1_1,   // DMA write, no tc (R5)
        13'b1_11_1_1_0_1_0_1_1_1_1_0,   // DMA read, tc -> WE low (R6)
        13'b1_11_1_1_0_0_0_1_1_1_1_1,   // DMA read, no tc (R6)
        13'b1_01_0_0_1_1_0_0_1_0_0_1,   // no dack: pass (R7)
        13'b1_00_1_0_1_1_0_1_0_0_1_0,   // source off: pass (R2)
        13'b0_10_1_1_0_1_1_0_1_1_0_1,   // not io mode: pass (R2)
        13'b1_01_1_1_1_1_0_0_0_0_0_0,   // dack without strobe (R7)
        13'b1_01_1_0_1_1_0_1_1_1_0_1    // inpack source write (R4)
    };

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic edge_wait(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    initial begin
        #100000;
        if (!done) begin
            errs++; checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        // R11: reset holds request low
        io_mode = 1'b1; dma_src = 2'b10; card_wp_io16_n = 1'b0;
        edge_wait(3);
        chk("R11 reset dreq", host_dreq, 1'b0);
        card_wp_io16_n = 1'b1;
        edge_wait(3);
        rst_n = 1'b1;
        edge_wait(3);
        chk("R11 idle dreq", host_dreq, 1'b0);

        // Vector table: R4 R5 R6 R7 R2
        for (int i = 0; i < 9; i++) begin
            {io_mode, dma_src, host_dack, host_iord_n, host_iowr_n, host_tc,
             host_reg_n, host_oe_n, host_we_n} = VEC[i][12:3];
            #1;
            chk("R4 card_reg_n", card_reg_n, VEC[i][2]);
            chk("R5 R7 card_oe_n", card_oe_n, VEC[i][1]);
            chk("R6 R7 card_we_n", card_we_n, VEC[i][0]);
            @(negedge clk);
        end
        host_dack = 1'b0; host_iord_n = 1'b1; host_iowr_n = 1'b1; host_tc = 1'b0;

        // R3 R1 R8: wp source, two-edge lag
        io_mode = 1'b1; dma_src = 2'b10;
        edge_wait(3);
        card_wp_io16_n = 1'b0;
        #1;
        chk("R8 status before sync", stat_wp_lvl, 1'b0);
        edge_wait(1);
        chk("R3 one edge", host_dreq, 1'b0);
        edge_wait(1);
        chk("R1 R3 two edges", host_dreq, 1'b1);
        chk("R8 status sync req", stat_wp_lvl, 1'b1);

        // R8: other source, raw pin level
        dma_src = 2'b01; card_inpack_n = 1'b1;
        #1;
        chk("R8 status raw", stat_wp_lvl, 1'b0);

        // R1: inpack source
        card_inpack_n = 1'b0;
        edge_wait(3);
        chk("R1 inpack req", host_dreq, 1'b1);

        // R2: source off drops request at once
        dma_src = 2'b00;
        #1;
        chk("R2 off dreq", host_dreq, 1'b0);

        // R1: speaker source
        card_inpack_n = 1'b1; dma_src = 2'b11; card_bvd2_spkr_n = 1'b0;
        edge_wait(3);
        chk("R1 spkr req", host_dreq, 1'b1);

        // R9: speaker muted, then passes under other source
        chk("R9 spkr muted", spkr_out, 1'b0);
        dma_src = 2'b01;
        #1;
        chk("R9 spkr pass", spkr_out, 1'b1);

        // R10: inack enable
        cfg_inack_en = 1'b1;
        #1;
        chk("R10 inack off", inack_en, 1'b0);
        dma_src = 2'b10;
        #1;
        chk("R10 inack pass", inack_en, 1'b1);
        io_mode = 1'b0; dma_src = 2'b01;
        #1;
        chk("R10 inack not io", inack_en, 1'b1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule